// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block paints a small two-bit-per-pixel cursor over a 24-bit pixel stream. A register write port loads a control word that holds the cursor's origin and its display options. That same write arms a capture of the next sixteen 32-bit writes, which become the cursor bitmap, one word per cursor line. Three further registers hold the 24-bit colours that the non-transparent cursor codes select.

While a frame is being shown, the block receives the horizontal cycle count and the line count from the timing generator. It compares them with the programmed origin, finds the cursor row and column, and reads the 2-bit code at that spot. It then either passes the incoming pixel through or replaces it with a cursor colour. The cursor can be doubled in width, in height, or in both. An interlace option makes each bitmap line cover the same line of both fields. The output is registered, so the output pixel lags the input pixel by one clock.

Top module: `hwc_overlay`

## Requirements
- R1: After reset the bitmap is all transparent, the three colours are zero, the origin is (0,0), no option is set and no capture is pending, so every pixel passes through.
- R2: `pix_out` and `cur_hit` are registered. Whenever no cursor pixel is drawn, `pix_out` equals the `pix_in` of the previous clock.
- R3: A cursor code of 00 passes `pix_in` through. Codes 01, 10 and 11 output the colour register at address 1, 2 or 3 respectively. A colour write stores `reg_wdata[23:0]`.
- R4: Within a bitmap word, bits [1:0] hold the leftmost cursor pixel and bits [31:30] hold the sixteenth pixel.
- R5: The control word at address 0 holds the X origin in bits [11:0] and the Y origin in bits [23:12]. Without doubling, cursor pixel (c,r) is shown at `h_cnt` = X+c and `v_cnt` = Y+r, for c and r from 0 to 15. Every position outside that window passes through.
- R6: After a control write, the next sixteen writes, at whatever address, are stored as bitmap lines 0 to 15 in that order.
- R7: `ext_dec_en` is high only for a write to an address above 3 while no capture is pending. During a capture, no colour register changes and `ext_dec_en` stays low.
- R8: Control bit 24 set makes each cursor pixel cover two consecutive `h_cnt` values, giving a window 32 cycles wide.
- R9: Control bit 25 set makes each bitmap line cover two consecutive display lines.
- R10: Control bit 26 (interlace) makes each bitmap line cover two consecutive frame lines, one from each field, giving 32 lines. Combined with bit 25, each bitmap line covers four lines.
- R11: While `disp_active` is low, the pixel passes through and `cur_hit` stays low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-path clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0 control, 1 to 3 colours |
| reg_wdata | input | 32 | Register write data |
| ext_dec_en | output | 1 | Write may be decoded by registers outside this block |
| disp_active | input | 1 | Active display region |
| h_cnt | input | 12 | Horizontal cycle count |
| v_cnt | input | 12 | Frame line count |
| pix_in | input | 24 | Incoming display pixel |
| pix_out | output | 24 | Pixel with the cursor applied, one clock later |
| cur_hit | output | 1 | Registered flag: a cursor colour replaced the pixel |

## Verification
The assertions assume that the timing generator keeps `disp_active` and the counters steady between clock edges. They also assume that register writes are single-cycle strobes whose address and data are valid together with `reg_we`. The bench changes every input one time unit after the rising edge and reads the outputs just before the next change, so no result depends on the order of processes at an edge. The bench places the cursor origin at least two counts away from zero, so that the scan margins around the window never wrap the unsigned counters.

// File: rtl/hwc_pkg.sv
`timescale 1ns/1ps
package hwc_pkg;
   localparam int CODE_BITS  = 2;
   localparam int NUM_COLORS = 3;
   localparam int ADDR_CTRL  = 0;

   typedef enum logic [CODE_BITS-1:0] {
      CODE_CLEAR = 2'd0,
      CODE_COL1  = 2'd1,
      CODE_COL2  = 2'd2,
      CODE_COL3  = 2'd3
   } hwc_code_e;

   typedef struct packed {
      logic ilace;
      logic dbl_v;
      logic dbl_h;
   } hwc_mode_t;
endpackage

// File: rtl/hwc_regs.sv
`timescale 1ns/1ps
module hwc_regs
   import hwc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int PIX_W  = 24,
   parameter int X_W    = 12,
   parameter int Y_W    = 12,
   parameter int ROWS   = 16,
   parameter int CNT_W  = $clog2(ROWS + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic [DATA_W-1:0]                 reg_wdata,
   output logic [X_W-1:0]                    x_start,
   output logic [Y_W-1:0]                    y_start,
   output hwc_mode_t                         mode,
   output logic [NUM_COLORS:1][PIX_W-1:0]    colors,
   output logic [ROWS-1:0][DATA_W-1:0]       bitmap,
   output logic [CNT_W-1:0]                  cap_left,
   output logic                              ext_dec_en
);
   localparam int MODE_LSB = X_W + Y_W;
   localparam int MODE_W   = $bits(hwc_mode_t);

   if (MODE_LSB + MODE_W > DATA_W) begin : g_bad_ctrl
      $error("hwc_regs: control fields do not fit in DATA_W");
   end
   if (PIX_W > DATA_W) begin : g_bad_pix
      $error("hwc_regs: PIX_W wider than DATA_W");
   end
   if ((1 << ADDR_W) <= NUM_COLORS + 1) begin : g_bad_addr
      $error("hwc_regs: ADDR_W too narrow for the register set");
   end

   logic             cap_busy;
   logic [CNT_W-1:0] cap_idx;
   logic             ctrl_wr;

   assign cap_busy   = (cap_left != '0);
   assign cap_idx    = CNT_W'(ROWS) - cap_left;
   assign ctrl_wr    = reg_we && !cap_busy && (reg_addr == ADDR_W'(ADDR_CTRL));
   assign ext_dec_en = reg_we && !cap_busy && (reg_addr > ADDR_W'(NUM_COLORS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_start  <= '0;
         y_start  <= '0;
         mode     <= '0;
         cap_left <= '0;
      end else if (ctrl_wr) begin
         x_start  <= reg_wdata[X_W-1:0];
         y_start  <= reg_wdata[X_W +: Y_W];
         mode     <= hwc_mode_t'(reg_wdata[MODE_LSB +: MODE_W]);
         cap_left <= CNT_W'(ROWS);
      end else if (reg_we && cap_busy) begin
         cap_left <= cap_left - 1'b1;
      end
   end

   for (genvar k = 1; k <= NUM_COLORS; k++) begin : g_color
      logic col_wr;
      assign col_wr = reg_we && !cap_busy && (reg_addr == ADDR_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      colors[k] <= '0;
         else if (col_wr) colors[k] <= reg_wdata[PIX_W-1:0];
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_line
      logic line_wr;
      assign line_wr = reg_we && cap_busy && (cap_idx == CNT_W'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       bitmap[r] <= '0;
         else if (line_wr) bitmap[r] <= reg_wdata;
      end
   end
endmodule

// File: rtl/hwc_locate.sv
`timescale 1ns/1ps
module hwc_locate
   import hwc_pkg::*;
#(
   parameter int X_W  = 12,
   parameter int Y_W  = 12,
   parameter int ROWS = 16,
   parameter int COLS = 16,
   parameter int RI_W = $clog2(ROWS),
   parameter int CI_W = $clog2(COLS)
) (
   input  logic [X_W-1:0]  h_cnt,
   input  logic [Y_W-1:0]  v_cnt,
   input  logic [X_W-1:0]  x_start,
   input  logic [Y_W-1:0]  y_start,
   input  hwc_mode_t       mode,
   output logic            hit_win,
   output logic [RI_W-1:0] row,
   output logic [CI_W-1:0] col
);
   if (X_W <= CI_W + 1 || Y_W <= RI_W + 2) begin : g_bad_w
      $error("hwc_locate: counter widths too small for the cursor");
   end

   logic [X_W:0]   dx;
   logic [Y_W:0]   dy;
   logic [X_W-1:0] col_full;
   logic [Y_W-1:0] row_full;
   logic [1:0]     v_shift;
   logic           in_x;
   logic           in_y;

   always_comb begin
      dx       = {1'b0, h_cnt} - {1'b0, x_start};
      dy       = {1'b0, v_cnt} - {1'b0, y_start};
      v_shift  = {1'b0, mode.dbl_v} + {1'b0, mode.ilace};
      col_full = dx[X_W-1:0] >> mode.dbl_h;
      row_full = dy[Y_W-1:0] >> v_shift;
      in_x     = !dx[X_W] && (col_full < X_W'(COLS));
      in_y     = !dy[Y_W] && (row_full < Y_W'(ROWS));
      hit_win  = in_x && in_y;
      col      = col_full[CI_W-1:0];
      row      = row_full[RI_W-1:0];
   end
endmodule

// File: rtl/hwc_pixmux.sv
`timescale 1ns/1ps
module hwc_pixmux
   import hwc_pkg::*;
#(
   parameter int PIX_W  = 24,
   parameter int DATA_W = 32,
   parameter int ROWS   = 16,
   parameter int COLS   = 16,
   parameter int RI_W   = $clog2(ROWS),
   parameter int CI_W   = $clog2(COLS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           disp_active,
   input  logic                           hit_win,
   input  logic [RI_W-1:0]                row,
   input  logic [CI_W-1:0]                col,
   input  logic [ROWS-1:0][DATA_W-1:0]    bitmap,
   input  logic [NUM_COLORS:1][PIX_W-1:0] colors,
   input  logic [PIX_W-1:0]               pix_in,
   output logic [PIX_W-1:0]               pix_out,
   output logic                           cur_hit
);
   localparam int NCHOICE = 1 << CODE_BITS;

   if (NCHOICE != NUM_COLORS + 1) begin : g_bad_codes
      $error("hwc_pixmux: colour count does not match the code width");
   end
   if (COLS * CODE_BITS != DATA_W) begin : g_bad_line
      $error("hwc_pixmux: a bitmap line must fill one data word");
   end

   logic [DATA_W-1:0] line;
   hwc_code_e         code;
   logic [PIX_W-1:0]  choice [NCHOICE];
   logic              draw;

   assign choice[0] = pix_in;
   for (genvar k = 1; k < NCHOICE; k++) begin : g_choice
      assign choice[k] = colors[k];
   end

   always_comb begin
      line = bitmap[row];
      code = hwc_code_e'(line[col*CODE_BITS +: CODE_BITS]);
      draw = disp_active && hit_win && (code != CODE_CLEAR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_out <= '0;
         cur_hit <= 1'b0;
      end else begin
         pix_out <= draw ? choice[code] : pix_in;
         cur_hit <= draw;
      end
   end
endmodule

// File: rtl/hwc_overlay.sv
`timescale 1ns/1ps
module hwc_overlay
   import hwc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int PIX_W  = 24,
   parameter int X_W    = 12,
   parameter int Y_W    = 12,
   parameter int ROWS   = 16,
   parameter int COLS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              ext_dec_en,
   input  logic              disp_active,
   input  logic [X_W-1:0]    h_cnt,
   input  logic [Y_W-1:0]    v_cnt,
   input  logic [PIX_W-1:0]  pix_in,
   output logic [PIX_W-1:0]  pix_out,
   output logic              cur_hit
);
   localparam int CNT_W = $clog2(ROWS + 1);
   localparam int RI_W  = $clog2(ROWS);
   localparam int CI_W  = $clog2(COLS);

   logic [X_W-1:0]                 x_start;
   logic [Y_W-1:0]                 y_start;
   hwc_mode_t                      mode;
   logic [NUM_COLORS:1][PIX_W-1:0] colors;
   logic [ROWS-1:0][DATA_W-1:0]    bitmap;
   logic [CNT_W-1:0]               cap_left;
   logic                           hit_win;
   logic [RI_W-1:0]                row;
   logic [CI_W-1:0]                col;

   hwc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W),
      .X_W(X_W), .Y_W(Y_W), .ROWS(ROWS), .CNT_W(CNT_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .x_start(x_start), .y_start(y_start),
      .mode(mode), .colors(colors), .bitmap(bitmap),
      .cap_left(cap_left), .ext_dec_en(ext_dec_en)
   );

   hwc_locate #(
      .X_W(X_W), .Y_W(Y_W), .ROWS(ROWS), .COLS(COLS),
      .RI_W(RI_W), .CI_W(CI_W)
   ) locate_i (
      .h_cnt(h_cnt), .v_cnt(v_cnt), .x_start(x_start), .y_start(y_start),
      .mode(mode), .hit_win(hit_win), .row(row), .col(col)
   );

   hwc_pixmux #(
      .PIX_W(PIX_W), .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS),
      .RI_W(RI_W), .CI_W(CI_W)
   ) mux_i (
      .clk(clk), .rst_n(rst_n), .disp_active(disp_active),
      .hit_win(hit_win), .row(row), .col(col), .bitmap(bitmap),
      .colors(colors), .pix_in(pix_in), .pix_out(pix_out),
      .cur_hit(cur_hit)
   );
endmodule

// File: rtl/hwc_overlay_chk.sv
`timescale 1ns/1ps
module hwc_overlay_chk #(
   parameter int PIX_W = 24,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             ext_dec_en,
   input logic             disp_active,
   input logic [PIX_W-1:0] pix_in,
   input logic [PIX_W-1:0] pix_out,
   input logic             cur_hit,
   input logic [CNT_W-1:0] cap_left
);
   logic started;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   p_miss_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !cur_hit) |-> (pix_out == $past(pix_in)));

   p_idle_passes_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(disp_active)) |-> (pix_out == $past(pix_in)) && !cur_hit);

   p_hit_needs_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cur_hit |-> $past(disp_active));

   p_no_decode_in_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_left != '0) |-> !ext_dec_en);

   p_capture_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(reg_we) && ($past(cap_left) != '0))
         |-> (cap_left == CNT_W'($past(cap_left) - 1'b1)));

   p_decode_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dec_en |-> reg_we);
endmodule

bind hwc_overlay hwc_overlay_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .ext_dec_en(ext_dec_en),
   .disp_active(disp_active), .pix_in(pix_in), .pix_out(pix_out),
   .cur_hit(cur_hit), .cap_left(cap_left)
);

// File: tb/hwc_overlay_tb.sv
`timescale 1ns/1ps
module hwc_overlay_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        ext_dec_en;
   logic        disp_active = 1'b0;
   logic [11:0] h_cnt = '0;
   logic [11:0] v_cnt = '0;
   logic [23:0] pix_in = '0;
   logic [23:0] pix_out;
   logic        cur_hit;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   // bench-side model of the programmed state
   logic [31:0] m_bm [16];
   logic [23:0] m_col [4];
   int m_xs, m_ys, m_cap;
   bit m_dh, m_dv, m_il;

   always #(CLK_P/2) clk = ~clk;

   hwc_overlay dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ext_dec_en(ext_dec_en),
      .disp_active(disp_active), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .pix_in(pix_in), .pix_out(pix_out), .cur_hit(cur_hit)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] pat(int h, int v);
      return {4'hC, h[9:0], v[9:0]};
   endfunction

   function automatic logic [31:0] gen_line(int r, int seed);
      logic [31:0] w;
      for (int c = 0; c < 16; c++) w[2*c +: 2] = 2'((r*3 + c*c + seed) % 4);
      return w;
   endfunction

   function automatic logic [23:0] model(int h, int v, bit act);
      int col, row;
      logic [1:0] code;
      if (!act || h < m_xs || v < m_ys) return pat(h, v);
      col = (h - m_xs) >> m_dh;
      row = (v - m_ys) >> (int'(m_dv) + int'(m_il));
      if (col >= 16 || row >= 16) return pat(h, v);
      code = m_bm[row][2*col +: 2];
      return (code == 2'b00) ? pat(h, v) : m_col[code];
   endfunction

   task automatic write_reg(string req, int addr, logic [31:0] data);
      bit exp_dec;
      exp_dec = (m_cap == 0) && (addr > 3);
      reg_we = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
      #1;
      check_val(req, {31'b0, ext_dec_en}, {31'b0, exp_dec});
      tick();
      reg_we = 1'b0;
      if (m_cap > 0) begin
         m_bm[16 - m_cap] = data;
         m_cap--;
      end else if (addr == 0) begin
         m_xs = int'(data[11:0]); m_ys = int'(data[23:12]);
         m_dh = data[24]; m_dv = data[25]; m_il = data[26];
         m_cap = 16;
      end else if (addr <= 3) begin
         m_col[addr] = data[23:0];
      end
   endtask

   task automatic probe(string req, int h, int v, bit act);
      logic [23:0] exp;
      h_cnt = 12'(h); v_cnt = 12'(v); disp_active = act; pix_in = pat(h, v);
      exp = model(h, v, act);
      tick();
      check_val(req, {8'b0, pix_out}, {8'b0, exp});
      check_val(req, {31'b0, cur_hit}, {31'b0, (act && exp != pat(h, v))});
   endtask

   task automatic scan(string req, bit act);
      int w, l;
      w = 16 << m_dh;
      l = 16 << (int'(m_dv) + int'(m_il));
      for (int v = m_ys - 2; v < m_ys + l + 2; v++)
         for (int h = m_xs - 2; h < m_xs + w + 2; h++)
            probe(req, h, v, act);
   endtask

   task automatic load_cursor(string req, int xs, int ys, bit dh, bit dv, bit il, int seed);
      write_reg(req, 0, {5'b0, il, dv, dh, 12'(ys), 12'(xs)});
      for (int r = 0; r < 16; r++) write_reg(req, 5, gen_line(r, seed));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) m_bm[i] = '0;
      for (int i = 0; i < 4; i++) m_col[i] = '0;
      m_xs = 0; m_ys = 0; m_cap = 0; m_dh = 0; m_dv = 0; m_il = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: transparent bitmap at origin, output follows input
      check_val("R1", {31'b0, ext_dec_en}, 32'd0);
      probe("R1", 0, 0, 1);
      probe("R1", 5, 3, 1);
      probe("R1", 15, 15, 1);
   endtask

   task automatic t_colours();
      write_reg("R3", 1, 32'hAA1F0A01);
      write_reg("R3", 2, 32'h552E0B02);
      write_reg("R3", 3, 32'h013D0C03);
   endtask

   task automatic t_basic();
      load_cursor("R6", 20, 10, 0, 0, 0, 1);
      scan("R3/R4/R5", 1);
   endtask

   task automatic t_order();
      write_reg("R6", 0, {8'b0, 12'd40, 12'd30});
      write_reg("R6", 5, 32'hC000_0001);
      for (int r = 1; r < 16; r++) write_reg("R6", 5, 32'h0);
      probe("R4", 30, 40, 1);
      probe("R4", 31, 40, 1);
      probe("R4", 44, 40, 1);
      probe("R4", 45, 40, 1);
      probe("R5", 29, 40, 1);
      probe("R5", 46, 40, 1);
      probe("R5", 30, 39, 1);
   endtask

   task automatic t_dbl_h();
      load_cursor("R6", 8, 6, 1, 0, 0, 2);
      scan("R8", 1);
   endtask

   task automatic t_dbl_v();
      load_cursor("R6", 12, 4, 0, 1, 0, 3);
      scan("R9", 1);
   endtask

   task automatic t_ilace();
      load_cursor("R6", 50, 20, 0, 0, 1, 0);
      scan("R10", 1);
      load_cursor("R6", 3, 2, 1, 1, 1, 1);
      scan("R10", 1);
   endtask

   task automatic t_inactive();
      load_cursor("R6", 20, 10, 0, 0, 0, 1);
      scan("R11", 0);
   endtask

   task automatic t_capture();
      write_reg("R7", 0, {8'b0, 12'd5, 12'd9});
      write_reg("R7", 1, 32'h5555_5555);
      write_reg("R7", 2, 32'h0);
      write_reg("R7", 0, 32'hFFFF_FFFF);
      for (int r = 3; r < 16; r++) write_reg("R7", r % 4, gen_line(r, 2));
      // colour 1 must still hold the value written before the capture
      probe("R7", 9, 5, 1);
      probe("R7", 24, 5, 1);
      scan("R6", 1);
   endtask

   task automatic t_decode();
      write_reg("R7", 5, 32'h0000_0003);
      write_reg("R7", 15, 32'hFFFF_FFFF);
      probe("R7", 9, 5, 1);
      probe("R7", 10, 7, 1);
      write_reg("R7", 2, 32'h00_777777);
      probe("R3", 10, 6, 1);
   endtask

   initial begin
      t_reset();
      t_colours();
      t_basic();
      t_order();
      t_dbl_h();
      t_dbl_v();
      t_ilace();
      t_inactive();
      t_capture();
      t_decode();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule